// File: doc/BRIEF.md
# Cable Echo Probe: Pulse Launcher and Reflection Monitor

This block tests a cable by sending a short pulse down one of its wire pairs and then watching the digitized echo that comes back. A software-style register front end gives it its settings. These are a global enable, a send strobe, a pulse width, a drive-style bit, pair selects for sending and for listening, a sample window and a threshold. The ADC delivers one signed sample per clock.

The send strobe launches the pulse and starts a sample timer on the same clock edge. The timer advances once per clock, and each tick stands for 8 ns. While the timer is inside an inclusive window, every sample is compared against a running extreme, which is either the largest value or the most negative value depending on a polarity bit. The same samples are compared against a threshold. The block stores the extreme value, the tick at which that value first appeared, and the tick of the first threshold crossing. When the timer reaches the window's stop value, the run ends. Software converts the stored ticks to distance using the propagation delay of the cable.

Top module: `echo_probe_top`

## Requirements
- R1: While `en_i` is low, `send_i` starts nothing: `busy_o` stays 0, `done_o` keeps its value, and both drive outputs and both pair outputs are 0. `takeover_o` equals `en_i`.
- R2: With `en_i` high and the block idle, a `send_i` sampled on a clock edge starts a run. The pulse drive is then high for exactly `width_i` clocks, in the clocks where the timer reads 0 through `width_i`-1. A width of 0 sends no pulse.
- R3: The pulse appears on `drive_data_o` when `fast_i`=1 (100 Mb data pulse) and on `drive_link_o` when `fast_i`=0 (10 Mb link pulse). `tx_pair_o` and `mon_pair_o` are 1 when the receive pair is chosen and 0 for the transmit pair; they follow `tx_sel_i` and `mon_sel_i` while enabled.
- R4: The timer starts at 0 at launch and steps by 1 each clock. A sample is counted only when the timer satisfies `win_lo_i` <= timer <= `win_hi_i`. If `win_lo_i` > `win_hi_i`, no sample is counted.
- R5: The run ends on the clock at which the timer equals `win_hi_i`, after that sample is taken. `done_o` then rises, `busy_o` falls and the timer holds. A run therefore lasts `win_hi_i`+1 clocks.
- R6: With `min_i`=0, `peak_o` holds the largest windowed signed sample. With `min_i`=1, it holds the most negative one.
- R7: `peak_time_o` is the tick of the first windowed sample that set the current peak. A later equal sample does not move it.
- R8: At launch the peak resets to -128 in max mode and +127 in min mode. If no sample falls in the window, that value remains and `peak_time_o` is 0.
- R9: `cross_time_o` is the tick of the first windowed sample that is strictly above `thresh_i` (max mode) or strictly below it (min mode), and `found_o` is set. With no crossing, `found_o` is 0 and `cross_time_o` is 0.
- R10: A new launch clears `done_o` and `found_o` on its start edge.
- R11: A `send_i` that arrives while `busy_o` is high is ignored, and the run finishes at its original time.
- R12: After reset, all outputs are 0 except `takeover_o` and the pair outputs, which follow their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick = 8 ns |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Global probe enable; takes over the pulse drivers |
| send_i | input | 1 | Launch strobe |
| width_i | input | 3 | Pulse width in clocks, 0 to 7 |
| fast_i | input | 1 | 1: 100 Mb data pulse, 0: 10 Mb link pulse |
| tx_sel_i | input | 1 | Send pair, 1 = receive pair |
| mon_sel_i | input | 1 | Listen pair, 1 = receive pair |
| min_i | input | 1 | 1: track most negative, 0: track largest |
| win_lo_i | input | 8 | First tick of the window |
| win_hi_i | input | 8 | Last tick of the window, end of run |
| thresh_i | input | 8 | Signed threshold |
| sample_i | input | 8 | Signed ADC sample |
| takeover_o | output | 1 | Drivers owned by the probe |
| drive_link_o | output | 1 | Link-pulse drive strobe |
| drive_data_o | output | 1 | Data-pulse drive strobe |
| tx_pair_o | output | 1 | Selected send pair |
| mon_pair_o | output | 1 | Selected listen pair |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished |
| peak_o | output | 8 | Signed extreme sample |
| peak_time_o | output | 8 | Tick of the first occurrence of the peak |
| found_o | output | 1 | Threshold crossing seen |
| cross_time_o | output | 8 | Tick of the first crossing |

## Verification
The hardest cases to reach are an echo that ties the current peak, an echo that lies just outside the window edges, and a second send that lands in the middle of a run. The stimulus handles these with one sample shape indexed by tick. That shape has a strong early pulse, a rising echo, an exact repeat of the echo's height later on, and a deep negative dip. Different window, threshold and polarity settings then point the monitor at each feature in turn. A dedicated run re-asserts the send strobe halfway through and checks that completion happens on the original tick. Empty and single-tick windows cover the peak reset values.

// File: rtl/echo_probe_pkg.sv
package echo_probe_pkg;
  localparam int SAMPLE_W = 8;
  localparam int TIME_W   = 8;
  localparam int PW_W     = 3;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic [TIME_W-1:0]          tick_t;

  // true when a is a better extreme than b for the chosen polarity
  function automatic logic beats(input logic min_mode, input sample_t a, input sample_t b);
    return min_mode ? (a < b) : (a > b);
  endfunction

  // starting value of the running extreme for a polarity
  function automatic sample_t peak_seed(input logic min_mode);
    sample_t s;
    s = '0;
    s[SAMPLE_W-1] = ~min_mode;
    for (int i = 0; i < SAMPLE_W-1; i++) s[i] = min_mode;
    return s;
  endfunction

  function automatic logic in_range(input tick_t t, input tick_t lo, input tick_t hi);
    return (t >= lo) && (t <= hi);
  endfunction
endpackage

// File: rtl/ep_pulse_gen.sv
module ep_pulse_gen
  import echo_probe_pkg::*;
#(
  parameter int WIDTH_W = PW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               start_i,
  input  logic               busy_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               drive_o
);
  logic [WIDTH_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (start_i)      left_q <= width_i;
    else if (!en_i)        left_q <= '0;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign drive_o = (left_q != '0) && busy_i && en_i;

  AST_PULSE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && width_i != '0) |=> (drive_o || !en_i)) else $error("pulse not launched"); // R2
  AST_PULSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && width_i == '0) |=> !drive_o) else $error("zero width drove"); // R2
endmodule

// File: rtl/ep_sample_timer.sv
module ep_sample_timer
  import echo_probe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  logic  start_i,
  input  tick_t win_lo_i,
  input  tick_t win_hi_i,
  output tick_t timer_o,
  output logic  busy_o,
  output logic  done_o,
  output logic  in_win_o,
  output logic  last_o
);
  tick_t timer_q;
  logic  busy_q, done_q;

  assign last_o   = busy_q && (timer_q == win_hi_i);
  assign in_win_o = busy_q && en_i && in_range(timer_q, win_lo_i, win_hi_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      timer_q <= '0;
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
    end else if (!en_i) begin
      busy_q  <= 1'b0;
    end else if (busy_q) begin
      if (last_o) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        timer_q <= timer_q + 1'b1;
      end
    end
  end

  assign timer_o = timer_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;

  AST_IDLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !busy_q) else $error("ran while disabled"); // R1
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && busy_q && !last_o && !start_i) |=> (busy_q && timer_q == $past(timer_q) + 1'b1))
    else $error("timer step or restart"); // R4 R11
  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> (done_q && $stable(timer_q))) else $error("timer moved after done"); // R5
  AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_q && timer_q == '0)) else $error("launch did not clear"); // R10
endmodule

// File: rtl/ep_extreme_tracker.sv
module ep_extreme_tracker
  import echo_probe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  logic    min_mode_i,
  input  logic    tick_i,
  input  tick_t   timer_i,
  input  sample_t sample_i,
  input  sample_t thresh_i,
  output sample_t peak_o,
  output tick_t   peak_time_o,
  output tick_t   cross_time_o,
  output logic    found_o
);
  sample_t peak_q;
  tick_t   ptime_q, ctime_q;
  logic    seen_q, found_q, min_q;
  logic    peak_upd, cross_hit;

  assign peak_upd  = tick_i && (!seen_q || beats(min_q, sample_i, peak_q));
  assign cross_hit = tick_i && !found_q && beats(min_q, sample_i, thresh_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q  <= '0;
      ptime_q <= '0;
      ctime_q <= '0;
      seen_q  <= 1'b0;
      found_q <= 1'b0;
      min_q   <= 1'b0;
    end else if (start_i) begin
      peak_q  <= peak_seed(min_mode_i);
      ptime_q <= '0;
      ctime_q <= '0;
      seen_q  <= 1'b0;
      found_q <= 1'b0;
      min_q   <= min_mode_i;
    end else begin
      if (peak_upd) begin
        peak_q  <= sample_i;
        ptime_q <= timer_i;
        seen_q  <= 1'b1;
      end
      if (cross_hit) begin
        ctime_q <= timer_i;
        found_q <= 1'b1;
      end
    end
  end

  assign peak_o       = peak_q;
  assign peak_time_o  = ptime_q;
  assign cross_time_o = ctime_q;
  assign found_o      = found_q;

  AST_PEAK_MONO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !min_q && seen_q) |=> (peak_q >= $past(peak_q))) else $error("max peak fell"); // R6
  AST_PEAK_MONO_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && min_q && seen_q) |=> (peak_q <= $past(peak_q))) else $error("min peak rose"); // R6
  AST_TIE_KEEPS_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && seen_q && tick_i && sample_i == peak_q) |=> $stable(ptime_q)) else $error("tie moved time"); // R7
  AST_FOUND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (found_q && !start_i) |=> (found_q && $stable(ctime_q))) else $error("crossing lost"); // R9
endmodule

// File: rtl/echo_probe_top.sv
module echo_probe_top
  import echo_probe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                send_i,
  input  logic [PW_W-1:0]     width_i,
  input  logic                fast_i,
  input  logic                tx_sel_i,
  input  logic                mon_sel_i,
  input  logic                min_i,
  input  logic [TIME_W-1:0]   win_lo_i,
  input  logic [TIME_W-1:0]   win_hi_i,
  input  logic [SAMPLE_W-1:0] thresh_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                takeover_o,
  output logic                drive_link_o,
  output logic                drive_data_o,
  output logic                tx_pair_o,
  output logic                mon_pair_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [SAMPLE_W-1:0] peak_o,
  output logic [TIME_W-1:0]   peak_time_o,
  output logic                found_o,
  output logic [TIME_W-1:0]   cross_time_o
);
  logic    launch, busy, done, in_win, last, drive;
  tick_t   timer;
  sample_t peak, samp, thr;

  assign launch = en_i && send_i && !busy;
  assign samp   = sample_t'(sample_i);
  assign thr    = sample_t'(thresh_i);

  ep_sample_timer u_timer (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(launch),
    .win_lo_i(win_lo_i), .win_hi_i(win_hi_i), .timer_o(timer),
    .busy_o(busy), .done_o(done), .in_win_o(in_win), .last_o(last)
  );

  ep_pulse_gen #(.WIDTH_W(PW_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(launch),
    .busy_i(busy), .width_i(width_i), .drive_o(drive)
  );

  ep_extreme_tracker u_track (
    .clk(clk), .rst_n(rst_n), .start_i(launch), .min_mode_i(min_i),
    .tick_i(in_win), .timer_i(timer), .sample_i(samp), .thresh_i(thr),
    .peak_o(peak), .peak_time_o(peak_time_o), .cross_time_o(cross_time_o),
    .found_o(found_o)
  );

  assign takeover_o   = en_i;
  assign drive_link_o = drive && !fast_i;
  assign drive_data_o = drive && fast_i;
  assign tx_pair_o    = en_i && tx_sel_i;
  assign mon_pair_o   = en_i && mon_sel_i;
  assign busy_o       = busy;
  assign done_o       = done;
  assign peak_o       = peak;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive_link_o, drive_data_o})) else $error("both drivers active"); // R3
  AST_DRIVE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_link_o || drive_data_o) |-> (busy_o && en_i)) else $error("drive outside run"); // R1
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last && en_i && !launch) |=> (done_o && !busy_o)) else $error("run did not end"); // R5
endmodule

// File: tb/echo_probe_top_tb_top.sv
module echo_probe_top_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en_i = 1'b0, send_i = 1'b0, fast_i = 1'b0, tx_sel_i = 1'b0, mon_sel_i = 1'b0, min_i = 1'b0;
  logic [2:0] width_i = '0;
  logic [7:0] win_lo_i = '0, win_hi_i = 8'd255, thresh_i = '0, sample_i = '0;
  logic takeover_o, drive_link_o, drive_data_o, tx_pair_o, mon_pair_o, busy_o, done_o, found_o;
  logic [7:0] peak_o, peak_time_o, cross_time_o;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  echo_probe_top dut_i (.*);

  typedef struct packed {
    logic mn; logic fs; logic tx; logic mo; logic [2:0] w;
    logic [7:0] lo; logic [7:0] hi; logic [7:0] th;
    logic [7:0] e_pk; logic [7:0] e_pt; logic e_fd; logic [7:0] e_ct;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0,1'b0,1'b0,1'b0,3'd3, 8'd0, 8'd255, 8'd20,  8'd100, 8'd2,  1'b1, 8'd2},
    '{1'b0,1'b1,1'b1,1'b0,3'd7, 8'd10,8'd255, 8'd20,  8'd70,  8'd41, 1'b1, 8'd40},
    '{1'b1,1'b0,1'b0,1'b1,3'd1, 8'd10,8'd255, 8'hCE,  8'hA6,  8'd60, 1'b1, 8'd60},
    '{1'b0,1'b0,1'b1,1'b1,3'd2, 8'd10,8'd50,  8'd80,  8'd70,  8'd41, 1'b0, 8'd0},
    '{1'b1,1'b1,1'b0,1'b0,3'd5, 8'd0, 8'd30,  8'hF6,  8'd0,   8'd0,  1'b0, 8'd0},
    '{1'b0,1'b0,1'b0,1'b0,3'd4, 8'd42,8'd44,  8'd0,   8'd0,   8'd42, 1'b0, 8'd0},
    '{1'b0,1'b1,1'b0,1'b1,3'd6, 8'd41,8'd41,  8'd69,  8'd70,  8'd41, 1'b1, 8'd41},
    '{1'b0,1'b0,1'b0,1'b0,3'd0, 8'd61,8'd61,  8'd5,   8'd0,   8'd61, 1'b0, 8'd0}
  };

  // echo shape: launch pulse at tick 2, rising echo 40/41, tie at 45, dip at 60
  function automatic logic [7:0] echo(input int t);
    case (t)
      2:  return 8'd100;
      40: return 8'd30;
      41: return 8'd70;
      45: return 8'd70;
      60: return 8'hA6; // -90
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // launch and feed one run; resend_at >= 0 re-pulses send mid-run
  task automatic run(input vec_t v, input int resend_at, output int pulses, output int bad_shape);
    int t;
    @(negedge clk);
    min_i = v.mn; fast_i = v.fs; tx_sel_i = v.tx; mon_sel_i = v.mo; width_i = v.w;
    win_lo_i = v.lo; win_hi_i = v.hi; thresh_i = v.th; send_i = 1'b1;
    @(posedge clk);
    pulses = 0; bad_shape = 0; t = 0;
    while (t <= int'(v.hi)) begin
      @(negedge clk);
      send_i = (t == resend_at);
      if (t == 0) begin
        chk("R10 done cleared", done_o, 0);
        chk("R10 found cleared", found_o, 0);
        chk("R3 send pair", tx_pair_o, v.tx);
        chk("R3 listen pair", mon_pair_o, v.mo);
      end
      if ((v.fs ? drive_data_o : drive_link_o)) pulses++;
      if ((v.fs ? drive_link_o : drive_data_o)) bad_shape++;
      if ((drive_link_o | drive_data_o) != (t < int'(v.w))) bad_shape++;
      sample_i = echo(t);
      t++;
    end
    @(negedge clk);
    send_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int p, b;
    vec_t d;
    repeat (3) @(negedge clk);
    tx_sel_i = 1'b1;
    // R12 reset state
    chk("R12 busy", busy_o, 0);
    chk("R12 done", done_o, 0);
    chk("R12 found", found_o, 0);
    chk("R12 peak", peak_o, 0);
    chk("R12 drive", drive_link_o | drive_data_o, 0);
    chk("R1 takeover low", takeover_o, 0);
    chk("R1 pair gated", tx_pair_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    en_i = 1'b1;

    foreach (VECS[i]) begin
      run(VECS[i], -1, p, b);
      chk($sformatf("R2 pulse count v%0d", i), p, VECS[i].w);
      chk($sformatf("R3 pulse shape v%0d", i), b, 0);
      chk($sformatf("R5 done v%0d", i), done_o, 1);
      chk($sformatf("R5 busy v%0d", i), busy_o, 0);
      chk($sformatf("R6 peak v%0d", i), peak_o, VECS[i].e_pk);
      chk($sformatf("R7 peak time v%0d", i), peak_time_o, VECS[i].e_pt);
      chk($sformatf("R9 found v%0d", i), found_o, VECS[i].e_fd);
      chk($sformatf("R9 cross time v%0d", i), cross_time_o, VECS[i].e_ct);
    end

    // R11: send re-asserted mid-run is ignored; run ends on original tick
    d = '{1'b0,1'b0,1'b0,1'b0,3'd3, 8'd0, 8'd100, 8'd20, 8'd100, 8'd2, 1'b1, 8'd2};
    run(d, 50, p, b);
    chk("R11 done on time", done_o, 1);
    chk("R11 peak kept", peak_o, 100);
    chk("R11 peak time kept", peak_time_o, 2);
    chk("R11 single pulse", p, 3);

    // R4 R8: empty window (lo > hi), max then min polarity
    d = '{1'b0,1'b0,1'b0,1'b0,3'd5, 8'd20, 8'd10, 8'd0, 8'd0, 8'd0, 1'b0, 8'd0};
    run(d, -1, p, b);
    chk("R8 empty max seed", peak_o, 8'h80);
    chk("R8 empty time", peak_time_o, 0);
    chk("R4 empty no crossing", found_o, 0);
    chk("R5 empty done", done_o, 1);
    d.mn = 1'b1;
    run(d, -1, p, b);
    chk("R8 empty min seed", peak_o, 8'h7F);

    // R1: disabled send is ignored, done keeps its value
    @(negedge clk);
    en_i = 1'b0; tx_sel_i = 1'b1; mon_sel_i = 1'b1; width_i = 3'd7; send_i = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R1 no drive", drive_link_o | drive_data_o, 0);
    end
    send_i = 1'b0;
    chk("R1 no busy", busy_o, 0);
    chk("R1 done kept", done_o, 1);
    chk("R1 takeover off", takeover_o, 0);
    chk("R1 pairs off", {tx_pair_o, mon_pair_o}, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule